// File: doc/BRIEF.md
# Ping-Pong Symbol Buffer Controller

This controller arbitrates a set of packet-sized symbol memories (two by default) between a writer and a reader. The writer fills a memory at bit rate. The reader empties a memory at the pace of the downstream modulator. The controller raises an upstream ready that tells the source when its modulation code, frame format and payload bits may be sampled. It selects which memory each side uses, and it gates the write and read strobes so that no memory is read before it holds a whole packet. No memory is written while it still holds unread data.

After the start pulse, ready stays high for each packet until that packet's write-done pulse. While priming, a write-done leaves ready high as long as another memory is still free. Once every memory is full, only a read-done can raise ready again. The result is that all memories are filled before steady-state alternation begins. The reader advances on read-done. A read-done and a write-done that arrive in the same cycle are both taken.

Top module: `pp_symbol_buf_ctrl`

## Requirements
- R1: After reset, ready_o, wr_en_o and rd_en_o are low and both bank selects are 0. ready_o stays low until a start_i pulse.
- R2: A start_i pulse raises ready_o in the following cycle. Any later start_i pulse has no effect.
- R3: ready_o, once high, stays high until an accepted write-done. During priming, each write-done keeps ready_o high while a free bank remains. When all banks are full, ready_o is low.
- R4: wr_bank_o advances by one (0,1,0,... with two banks) one cycle after each accepted write-done. rd_bank_o advances the same way one cycle after each accepted read-done. Neither moves otherwise.
- R5: rd_en_o equals mod_ready_i while the bank selected by rd_bank_o holds a complete unread packet, and is 0 otherwise.
- R6: wr_en_o equals wr_valid_i while ready_o is high, and is 0 otherwise. When both strobes are high, the two bank selects differ.
- R7: With all banks full, an accepted read-done raises ready_o in the next cycle.
- R8: A write-done and a read-done in the same cycle are both accepted: both bank selects advance, and ready_o reflects the freed bank.
- R9: A write-done while ready_o is low, and a read-done while the read bank is empty, are ignored: no bank select or ready change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that enables packet acceptance |
| wr_valid_i | input | 1 | Writer has a processed bit/symbol to store |
| wr_done_i | input | 1 | Pulse: current packet fully written |
| rd_done_i | input | 1 | Pulse: reader finished draining a packet |
| mod_ready_i | input | 1 | Downstream modulator can take a symbol |
| ready_o | output | 1 | Source may present MCS, format and payload bits |
| wr_bank_o | output | BANK_W | Memory selected for writing |
| rd_bank_o | output | BANK_W | Memory selected for reading |
| wr_en_o | output | 1 | Write strobe to the selected write memory |
| rd_en_o | output | 1 | Read strobe to the selected read memory |

## Verification
Directed sequences cover the cases that separate a correct controller from a near miss. These are a write-done before start, a repeated start, the end of priming, a read-done that revives ready, coincident read-done and write-done, and a read-done on an empty bank. Together they distinguish gating by ready or by fill state from free-running toggles. A long constrained-random run then drives all five inputs with biased pulse rates. A bench model of bank fill states predicts every output on every cycle. This exposes lost coincident events and off-by-one bank selects.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  localparam int unsigned PP_DEF_BANKS = 2;

  typedef struct packed {
    logic wr_acc;
    logic rd_acc;
  } pp_evt_t;
endpackage

// File: rtl/pp_bank_ptr.sv
module pp_bank_ptr #(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [BANK_W-1:0] ptr_o
);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o)); // R4
  AST_PTR_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o != $past(ptr_o)); // R4
endmodule

// File: rtl/pp_fill_flags.sv
module pp_fill_flags #(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [BANK_W-1:0]    set_idx_i,
  input  logic                 clr_i,
  input  logic [BANK_W-1:0]    clr_idx_i,
  output logic [NUM_BANKS-1:0] full_o
);
  logic [NUM_BANKS-1:0] full_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    full_q[b] <= 1'b0;
      else if (set_i && set_idx_i == BANK_W'(b))      full_q[b] <= 1'b1;
      else if (clr_i && clr_idx_i == BANK_W'(b))      full_q[b] <= 1'b0;
    end
  end

  assign full_o = full_q;

  AST_SET_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !full_o[set_idx_i]); // R6
  AST_CLR_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> full_o[clr_idx_i]); // R5
endmodule

// File: rtl/pp_ready_gen.sv
module pp_ready_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_free_i,
  output logic ready_o
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      started_q <= 1'b0;
    else if (start_i) started_q <= 1'b1;
  end

  // free bank ahead of the writer is what re-arms ready
  assign ready_o = started_q & wr_free_i;

  AST_START_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q); // R2
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !started_q) |=> started_q); // R2
endmodule

// File: rtl/pp_symbol_buf_ctrl.sv
module pp_symbol_buf_ctrl
  import pp_buf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = PP_DEF_BANKS,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_valid_i,
  input  logic              wr_done_i,
  input  logic              rd_done_i,
  input  logic              mod_ready_i,
  output logic              ready_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic              wr_en_o,
  output logic              rd_en_o
);
  pp_evt_t              evt;
  logic [NUM_BANKS-1:0] full;
  logic [BANK_W-1:0]    wr_ptr, rd_ptr;
  logic                 rd_has_pkt, wr_free;

  assign rd_has_pkt = full[rd_ptr];
  assign wr_free    = ~full[wr_ptr];
  assign evt.wr_acc = wr_done_i & ready_o;
  assign evt.rd_acc = rd_done_i & rd_has_pkt;

  pp_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(evt.wr_acc), .ptr_o(wr_ptr));

  pp_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(evt.rd_acc), .ptr_o(rd_ptr));

  pp_fill_flags #(.NUM_BANKS(NUM_BANKS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(evt.wr_acc), .set_idx_i(wr_ptr),
    .clr_i(evt.rd_acc), .clr_idx_i(rd_ptr),
    .full_o(full));

  pp_ready_gen u_ready (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .wr_free_i(wr_free), .ready_o(ready_o));

  assign wr_bank_o = wr_ptr;
  assign rd_bank_o = rd_ptr;
  assign wr_en_o   = wr_valid_i & ready_o;
  assign rd_en_o   = mod_ready_i & rd_has_pkt;

  AST_BANKS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && rd_en_o) |-> wr_bank_o != rd_bank_o); // R6
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.wr_acc && !evt.rd_acc && $countones(full) == NUM_BANKS - 1) |=> !ready_o); // R3
  AST_READY_REVIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !wr_done_i) |=> ready_o); // R3
  AST_FULL_READ_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&full && evt.rd_acc && $past(ready_o) == ready_o && !ready_o && $rose(rst_ni) == 1'b0
     && u_ready.started_q) |=> ready_o); // R7
  AST_RD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_has_pkt |-> !rd_en_o); // R5
endmodule

// File: tb/pp_symbol_buf_ctrl_tb_top.sv
module pp_symbol_buf_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, wv, wd, rdn, mr;
  logic ready, wr_en, rd_en;
  logic wb, rb;

  always #10 clk = ~clk;

  pp_symbol_buf_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_valid_i(wv),
    .wr_done_i(wd), .rd_done_i(rdn), .mod_ready_i(mr), .ready_o(ready),
    .wr_bank_o(wb), .rd_bank_o(rb), .wr_en_o(wr_en), .rd_en_o(rd_en));

  int checks = 0;
  int errors = 0;
  bit m_started = 0;
  bit m_full [2] = '{0, 0};
  int m_wp = 0;
  int m_rp = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ready();
    return (m_started && !m_full[m_wp]) ? 1 : 0;
  endfunction

  task automatic cycle(bit s, bit w, bit r, bit m, bit v);
    bit wa, ra;
    @(negedge clk);
    start = s; wd = w; rdn = r; mr = m; wv = v;
    #1;
    chk("R3 ready", int'(ready), exp_ready());
    chk("R4 wr_bank", int'(wb), m_wp);
    chk("R4 rd_bank", int'(rb), m_rp);
    chk("R5 rd_en", int'(rd_en), (m && m_full[m_rp]) ? 1 : 0);
    chk("R6 wr_en", int'(wr_en), (v && exp_ready() == 1) ? 1 : 0);
    @(posedge clk);
    wa = w && exp_ready() == 1;
    ra = r && m_full[m_rp];
    if (s) m_started = 1;
    if (wa) begin m_full[m_wp] = 1; m_wp ^= 1; end
    if (ra) begin m_full[m_rp] = 0; m_rp ^= 1; end
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    start = 0; wv = 0; wd = 0; rdn = 0; mr = 0;
    #35 rst_n = 1'b1;
    #1;
    chk("R1 ready", int'(ready), 0);
    chk("R1 wr_bank", int'(wb), 0);
    chk("R1 rd_bank", int'(rb), 0);
    chk("R1 enables", int'(wr_en) + int'(rd_en), 0);
    cycle(0, 1, 0, 1, 1);
    chk("R9 wr_done before start", int'(wb), 0);
    chk("R1 ready before start", int'(ready), 0);
    cycle(1, 0, 0, 0, 1);
    chk("R2 start raises ready", int'(ready), 1);
    cycle(0, 1, 0, 0, 1);
    chk("R3 priming keeps ready", int'(ready), 1);
    chk("R4 wr_bank toggled", int'(wb), 1);
    cycle(0, 1, 0, 1, 1);
    chk("R3 all full drops ready", int'(ready), 0);
    cycle(1, 0, 0, 1, 1);
    chk("R2 second start ignored", int'(ready), 0);
    cycle(0, 1, 0, 0, 1);
    chk("R9 wr_done while not ready", int'(wb), 0);
    cycle(0, 0, 1, 1, 1);
    chk("R7 read-done revives ready", int'(ready), 1);
    chk("R7 rd_bank toggled", int'(rb), 1);
    cycle(0, 1, 1, 1, 1);
    chk("R8 both wr_bank", int'(wb), 1);
    chk("R8 both rd_bank", int'(rb), 0);
    chk("R8 ready after both", int'(ready), 1);
    cycle(0, 0, 1, 1, 0);
    cycle(0, 0, 1, 1, 0);
    chk("R9 rd_done on empty bank", int'(rb), 1);
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom_range(0, 99) < 2), ($urandom_range(0, 9) < 3),
            ($urandom_range(0, 9) < 3), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule